// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Timer Override

This block drives an 8-bit bank of general-purpose pins from two software-visible registers on a simple register bus. One register holds the output data. The other holds one direction bit per pin. Each pin leaves the block as a value plus an output enable, which a tri-state pad consumes. Pin levels coming back in pass through a two-stage synchronizer before software can read them.

The low six pins double as timer capture/compare channels. Each channel has a 2-bit mode field. Any nonzero value hands the pin to the timer. The timer's direction and compare output then drive the pad, and the direction register no longer affects it. Reading the data register still follows the direction bit for every pin: a direction of 1 returns the stored data bit, and a direction of 0 returns the synchronized pin level. This holds whether or not the timer owns the pin.

Reset clears the direction register, so every pin starts as an input. Reset leaves the data register alone.

Top module: `shared_pin_port`

## Requirements
- R1: While reset is asserted and after it, the direction register reads 0 and no pin that is not timer-owned has its output enable set.
- R2: A bus write to offset 1 stores the write data in the direction register on that clock edge, and a read at offset 1 returns the last value written.
- R3: For a pin not owned by a timer, the output enable equals its direction bit and the pin output equals its data-register bit.
- R4: A read at offset 0 returns, for each bit, the data-register bit when the direction bit is 1 and the synchronized pin level when the direction bit is 0.
- R5: Pin i (i from 0 to 5) is timer-owned when mode bits [2i+1:2i] are nonzero. An owned pin takes its output enable from the timer direction input i and its output value from the timer output input i, whatever its direction bit. Pins 7 and 6 are never owned.
- R6: The read selection of R4 by the direction bit applies unchanged to timer-owned pins.
- R7: A write at offset 0 updates every data-register bit, including owned ones. When an owned pin's mode field returns to 00, the stored bit appears on that pin in the same cycle.
- R8: Reset does not alter the data register. A value written before reset reads back after reset once the direction bits are set to 1.
- R9: Reads at offsets 2 and 3 return 0. Writes to them change neither register.
- R10: A pin level change reaches the read value after exactly two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register offset (0 data, 1 direction) |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the offset |
| tmrModeSel | input | 12 | Per-channel 2-bit mode fields; nonzero claims the pin |
| tmrOutVal | input | 6 | Per-channel compare output value |
| tmrOutDir | input | 6 | Per-channel drive enable (1 = drive) |
| padIn | input | 8 | Pin levels from the pads |
| padOut | output | 8 | Pin output values |
| padOe | output | 8 | Pin output enables (1 = drive) |

## Verification
The case of interest is a channel releasing its pin in the same cycle that software writes the data register. For that one cycle the pin must show the previously stored bit, and the newly written bit must appear from the next cycle on. A directed sequence sets this up on pin 0 and checks the pin in both cycles. The random phase then mixes mode-field changes with writes to both registers, so that takeovers and releases often coincide with direction writes and pin changes. A bench model tracks the registers and a two-deep pin history, and judges the read value and both pin vectors every cycle.

// File: rtl/spp_pkg.sv
package spp_pkg;
  // Strobes from the decode stage to the datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
  } sppStrobe_t;
endpackage

// File: rtl/spp_ctrl.sv
module spp_ctrl
  import spp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int TIMER_PINS = 6,
  parameter int ADDR_W     = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS = 0,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 1
) (
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [2*TIMER_PINS-1:0] tmrModeSel,
  output sppStrobe_t              strb,
  output logic [WIDTH-1:0]        ownMask
);
  logic hitData;
  logic hitDir;

  assign hitData = (busAddr == DATA_OFS);
  assign hitDir  = (busAddr == DIR_OFS);

  always_comb begin
    strb.wrData = busWrEn & hitData;
    strb.wrDir  = busWrEn & hitDir;
    strb.rdData = hitData;
    strb.rdDir  = hitDir;
  end

  // A channel claims its pin when its mode field is nonzero
  for (genvar i = 0; i < WIDTH; i++) begin : g_own
    if (i < TIMER_PINS) begin : g_tmr
      assign ownMask[i] = |tmrModeSel[2*i +: 2];
    end else begin : g_plain
      assign ownMask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spp_datapath.sv
module spp_datapath
  import spp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int TIMER_PINS  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sppStrobe_t            strb,
  input  logic [WIDTH-1:0]      busWrData,
  input  logic [WIDTH-1:0]      ownMask,
  input  logic [TIMER_PINS-1:0] tmrOutVal,
  input  logic [TIMER_PINS-1:0] tmrOutDir,
  input  logic [WIDTH-1:0]      padIn,
  output logic [WIDTH-1:0]      padOut,
  output logic [WIDTH-1:0]      padOe,
  output logic [WIDTH-1:0]      busRdData
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latchReg;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncPipe;
  logic [WIDTH-1:0] pinSeen;
  logic [WIDTH-1:0] portView;

  // Direction register: cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirReg <= '0;
    else if (strb.wrDir) dirReg <= busWrData;
  end

  // Data latch: deliberately untouched by reset
  always_ff @(posedge clk) begin
    if (rstN && strb.wrData) latchReg <= busWrData;
  end

  // Input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncPipe[k] <= syncPipe[k-1];
    end
  end
  assign pinSeen = syncPipe[LAST];

  // Pin drive: timer channel or GPIO registers
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < TIMER_PINS) begin : g_shared
      always_comb begin
        if (ownMask[i]) begin
          padOe[i]  = tmrOutDir[i];
          padOut[i] = tmrOutVal[i];
        end else begin
          padOe[i]  = dirReg[i];
          padOut[i] = latchReg[i];
        end
      end
    end else begin : g_gpio
      assign padOe[i]  = dirReg[i];
      assign padOut[i] = latchReg[i];
    end
  end

  // Read-back selection is by direction bit only
  assign portView = (dirReg & latchReg) | (~dirReg & pinSeen);

  always_comb begin
    if (strb.rdData)     busRdData = portView;
    else if (strb.rdDir) busRdData = dirReg;
    else                 busRdData = '0;
  end
endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
  import spp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int TIMER_PINS  = 6,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [WIDTH-1:0]        busWrData,
  output logic [WIDTH-1:0]        busRdData,
  input  logic [2*TIMER_PINS-1:0] tmrModeSel,
  input  logic [TIMER_PINS-1:0]   tmrOutVal,
  input  logic [TIMER_PINS-1:0]   tmrOutDir,
  input  logic [WIDTH-1:0]        padIn,
  output logic [WIDTH-1:0]        padOut,
  output logic [WIDTH-1:0]        padOe
);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DIR_OFS  = ADDR_W'(1);

  sppStrobe_t       strb;
  logic [WIDTH-1:0] ownMask;

  spp_ctrl #(
    .WIDTH(WIDTH), .TIMER_PINS(TIMER_PINS), .ADDR_W(ADDR_W),
    .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .tmrModeSel(tmrModeSel),
    .strb(strb), .ownMask(ownMask)
  );

  spp_datapath #(
    .WIDTH(WIDTH), .TIMER_PINS(TIMER_PINS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .ownMask(ownMask), .tmrOutVal(tmrOutVal), .tmrOutDir(tmrOutDir),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .busRdData(busRdData)
  );
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
  parameter int WIDTH       = 8,
  parameter int TIMER_PINS  = 6,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWrEn,
  input logic [WIDTH-1:0]        busWrData,
  input logic [WIDTH-1:0]        busRdData,
  input logic [2*TIMER_PINS-1:0] tmrModeSel,
  input logic [TIMER_PINS-1:0]   tmrOutVal,
  input logic [TIMER_PINS-1:0]   tmrOutDir,
  input logic [WIDTH-1:0]        padIn,
  input logic [WIDTH-1:0]        padOut,
  input logic [WIDTH-1:0]        padOe
);
  logic [WIDTH-1:0] shadowDir;
  logic [WIDTH-1:0] ownSeen;
  logic [WIDTH-1:0] tDirW;
  logic [WIDTH-1:0] tValW;
  logic [1:0]       upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowDir <= '0;
    else if (busWrEn && busAddr == ADDR_W'(1)) shadowDir <= busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  always_comb begin
    ownSeen = '0;
    tDirW   = '0;
    tValW   = '0;
    for (int i = 0; i < TIMER_PINS; i++) begin
      ownSeen[i] = tmrModeSel[2*i] | tmrModeSel[2*i+1];
      tDirW[i]   = tmrOutDir[i];
      tValW[i]   = tmrOutVal[i];
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> ((padOe & ~ownSeen) == '0)); // R1

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(1)) |-> (busRdData == shadowDir)); // R2

  AST_GPIO_OE: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & ~ownSeen) == (shadowDir & ~ownSeen))); // R3

  AST_TIMER_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ tDirW) | (padOut ^ tValW)) & ownSeen) == '0); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:1] != '0) |-> (busRdData == '0)); // R9

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && busAddr == ADDR_W'(0))
      |-> (((busRdData ^ $past(padIn, 2)) & ~shadowDir) == '0)); // R10
endmodule

bind shared_pin_port spp_checker #(
  .WIDTH(WIDTH), .TIMER_PINS(TIMER_PINS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_spp_checker (.*);

// File: tb/shared_pin_port_bench.sv
module shared_pin_port_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  busAddr;
  logic        busWrEn;
  logic [7:0]  busWrData;
  logic [7:0]  busRdData;
  logic [11:0] tmrModeSel;
  logic [5:0]  tmrOutVal;
  logic [5:0]  tmrOutDir;
  logic [7:0]  padIn;
  logic [7:0]  padOut;
  logic [7:0]  padOe;

  always #5 clk = ~clk;

  shared_pin_port u_shared_pin_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tmrModeSel(tmrModeSel),
    .tmrOutVal(tmrOutVal), .tmrOutDir(tmrOutDir), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model
  logic [7:0] mLatch = '0, mKnown = '0, mDir = '0, mS1 = '0, mS2 = '0;
  logic [7:0] lastRd, lastOut, lastOe;

  function automatic logic [7:0] ownOf(input logic [11:0] sel);
    logic [7:0] o = '0;
    for (int i = 0; i < 6; i++) o[i] = (sel[2*i +: 2] != 2'b00);
    return o;
  endfunction

  function automatic logic [7:0] expPort();
    return (mDir & mLatch) | (~mDir & mS2);
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp, input logic [7:0] mask);
    checks++;
    if (((act ^ exp) & mask) != 8'h00) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h mask=%h", req, act, exp, mask);
    end
  endtask

  task automatic step(input logic rst, input logic wr, input logic [1:0] addr,
                      input logic [7:0] wd, input logic [7:0] pin,
                      input logic [11:0] sel, input logic [5:0] tv, input logic [5:0] td);
    logic [7:0] own;
    @(negedge clk);
    rstN = rst; busWrEn = wr; busAddr = addr; busWrData = wd;
    padIn = pin; tmrModeSel = sel; tmrOutVal = tv; tmrOutDir = td;
    if (!rst) begin mDir = '0; mS1 = '0; mS2 = '0; end
    #1;
    lastRd = busRdData; lastOut = padOut; lastOe = padOe;
    own = ownOf(sel);
    if (addr == 2'd0)      check("R4/R6 data read", busRdData, expPort(), ~mDir | mKnown);
    else if (addr == 2'd1) check("R2 dir read", busRdData, mDir, 8'hFF);
    else                   check("R9 unmapped read", busRdData, 8'h00, 8'hFF);
    check("R1/R3 gpio oe", padOe, mDir, ~own);
    check("R3/R7 gpio out", padOut, mLatch, ~own & mDir & mKnown);
    check("R5 timer oe", padOe, {2'b00, td}, own);
    check("R5 timer out", padOut, {2'b00, tv}, own);
    @(posedge clk);
    if (rst) begin
      if (wr && addr == 2'd0) begin mLatch = wd; mKnown = 8'hFF; end
      if (wr && addr == 2'd1) mDir = wd;
      mS2 = mS1; mS1 = pin;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; busWrEn = 0; busAddr = 0; busWrData = 0;
    padIn = 0; tmrModeSel = 0; tmrOutVal = 0; tmrOutDir = 0;

    // R1: reset state
    step(0, 0, 2'd1, 8'h00, 8'h00, 12'h000, 6'h3F, 6'h3F);
    step(0, 1, 2'd1, 8'hFF, 8'h00, 12'h000, 6'h3F, 6'h3F);
    @(negedge clk); #1;
    check("R1 dir in reset", busRdData, 8'h00, 8'hFF);
    check("R1 oe in reset", padOe, 8'h00, 8'hFF);

    // R8: latch survives reset
    step(1, 1, 2'd0, 8'hA5, 8'h00, 12'h000, 0, 0);
    step(1, 1, 2'd1, 8'hFF, 8'h00, 12'h000, 0, 0);
    step(0, 0, 2'd1, 8'h00, 8'h00, 12'h000, 0, 0);
    step(0, 0, 2'd1, 8'h00, 8'h00, 12'h000, 0, 0);
    check("R1 dir after reset", lastRd, 8'h00, 8'hFF);
    step(1, 1, 2'd1, 8'hFF, 8'h00, 12'h000, 0, 0);
    step(1, 0, 2'd0, 8'h00, 8'h00, 12'h000, 0, 0);
    check("R8 latch kept", lastRd, 8'hA5, 8'hFF);

    // R9: unmapped writes ignored
    step(1, 1, 2'd2, 8'h00, 8'h00, 12'h000, 0, 0);
    step(1, 1, 2'd3, 8'h00, 8'h00, 12'h000, 0, 0);
    step(1, 0, 2'd1, 8'h00, 8'h00, 12'h000, 0, 0);
    check("R9 dir unchanged", lastRd, 8'hFF, 8'hFF);
    step(1, 0, 2'd0, 8'h00, 8'h00, 12'h000, 0, 0);
    check("R9 latch unchanged", lastRd, 8'hA5, 8'hFF);

    // R10: two-edge input latency
    step(1, 1, 2'd1, 8'h00, 8'h00, 12'h000, 0, 0);
    step(1, 0, 2'd0, 8'h00, 8'h00, 12'h000, 0, 0);
    step(1, 0, 2'd0, 8'h00, 8'h00, 12'h000, 0, 0);
    step(1, 0, 2'd0, 8'h00, 8'h3C, 12'h000, 0, 0);
    step(1, 0, 2'd0, 8'h00, 8'h3C, 12'h000, 0, 0);
    check("R10 one edge", lastRd, 8'h00, 8'hFF);
    step(1, 0, 2'd0, 8'h00, 8'h3C, 12'h000, 0, 0);
    check("R10 two edges", lastRd, 8'h3C, 8'hFF);

    // R6: owned pin with dir 0 still reads pin
    step(1, 0, 2'd0, 8'h00, 8'h3C, 12'h0F0, 6'h3F, 6'h3F);
    check("R6 owned read pin", lastRd, 8'h3C, 8'hFF);

    // R5/R7: takeover and release with same-cycle write
    step(1, 1, 2'd1, 8'hFF, 8'h00, 12'h000, 0, 0);
    step(1, 1, 2'd0, 8'h01, 8'h00, 12'h001, 6'h00, 6'h01);
    check("R5 timer drives pin0", lastOut & 8'h01, 8'h00, 8'hFF);
    step(1, 1, 2'd0, 8'h00, 8'h00, 12'h000, 6'h00, 6'h00);
    check("R7 release shows stored bit", lastOut & 8'h01, 8'h01, 8'hFF);
    check("R7 release oe from dir", lastOe & 8'h01, 8'h01, 8'hFF);
    step(1, 0, 2'd0, 8'h00, 8'h00, 12'h000, 0, 0);
    check("R7 new bit next cycle", lastOut & 8'h01, 8'h00, 8'hFF);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] sel;
      sel = '0;
      for (int c = 0; c < 6; c++)
        if ($urandom_range(1, 0) == 1) sel[2*c +: 2] = 2'($urandom_range(3, 1));
      step(($urandom_range(99, 0) != 0), ($urandom_range(2, 0) == 0),
           2'($urandom_range(3, 0)), 8'($urandom), 8'($urandom), sel,
           6'($urandom), 6'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule